// File: doc/BRIEF.md
# Sixteen-bit multi-cycle controller-plus-datapath processor

A small 16-bit processor made of a state machine and a datapath. The datapath holds a program counter, an instruction register, sixteen 16-bit general registers and one adder/subtractor. Instructions and data share a single memory port. The environment answers a read with data in the same cycle that the address is driven. The processor drives the address, the write data and the read and write strobes on that port.

Every instruction takes exactly three clock cycles:
- Fetch: the word at the program counter is read into the instruction register, and the program counter advances by one.
- Decode: the opcode selects the next state.
- Execute: one state per instruction, then back to fetch.

The states are FETCH, DECODE, LDD (load direct), STD (store direct), STI (store through register), LDI (load immediate), ADD, SUB, JZ (jump if zero) and HALT. The transitions are:
- reset goes to FETCH;
- FETCH goes to DECODE;
- DECODE goes to one execute state, chosen by opcode, or to HALT for an undefined opcode;
- every execute state goes to FETCH;
- HALT stays in HALT until reset.

An instruction word has four fields:
- the opcode in bits 15:12;
- the first register (n) in bits 11:8;
- the second register (m) in bits 7:4;
- an 8-bit field in bits 7:0, used as a direct address, an immediate or a jump target, and zero-extended to 16 bits.

Top module: `mc_cpu16`

## Requirements
- R1: While `rst` is high on a clock edge, the program counter becomes 0, the state becomes FETCH and `halted` goes low. In the following cycle the block drives `mem_addr`=0 with `mem_rd`=1 and `mem_wr`=0.
- R2: Every defined instruction takes three cycles. FETCH drives `mem_addr`=PC with `mem_rd`=1, loads the instruction register and adds one to the PC. DECODE drives neither strobe. The execute state returns to FETCH, so the next fetch comes three cycles after the previous one.
- R3: Opcode 0011 writes the zero-extended bits 7:0 into register n.
- R4: Opcode 0000 reads memory at the zero-extended bits 7:0 (`mem_rd`=1) into register n. Opcode 0001 writes register n to that address (`mem_wr`=1).
- R5: Opcode 0010 writes register m to the memory address held in register n. When n equals m, both the address and the data are that register's value.
- R6: Opcode 0100 sets register n to n+m, and opcode 0101 sets it to n-m, both modulo 2^16. When n equals m, the add doubles the register.
- R7: Opcode 0110 loads the PC with the zero-extended bits 7:0 when register n is zero. Otherwise execution continues at the next word.
- R8: Opcodes 0111 to 1111 lead from DECODE to HALT. In HALT, `halted` is 1, both strobes are 0, and this lasts until reset.
- R9: `mem_rd` and `mem_wr` are never high together, and `mem_wr` is high only in the STD and STI states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| halted | output | 1 | High while stopped on an undefined opcode |

## Verification
In the store-through-register instruction, the address read and the data read can land on the same register in one execute cycle. The program provokes this with a store whose two register fields are equal, and the word written at that register's address must equal its own value. A second collision is a register that is both operand and destination of an add: doubling a value loaded back from memory must give 110 from 55. The end state of a summation loop also checks that the jump taken and the jump not taken each fell on the correct cycle. It does so through an exact count of 188 cycles from reset release to halt.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
    localparam int OP_W    = 4;
    localparam int REG_AW  = 4;
    localparam int FIELD_W = 8;

    localparam logic [OP_W-1:0] OP_LDD = 4'h0;
    localparam logic [OP_W-1:0] OP_STD = 4'h1;
    localparam logic [OP_W-1:0] OP_STI = 4'h2;
    localparam logic [OP_W-1:0] OP_LDI = 4'h3;
    localparam logic [OP_W-1:0] OP_ADD = 4'h4;
    localparam logic [OP_W-1:0] OP_SUB = 4'h5;
    localparam logic [OP_W-1:0] OP_JZ  = 4'h6;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_LDD, ST_STD, ST_STI,
        ST_LDI, ST_ADD, ST_SUB, ST_JZ, ST_HALT
    } state_e;

    typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01} alu_sel_e;
    typedef enum logic [1:0] {WB_ALU = 2'b00, WB_MEM = 2'b01, WB_IMM = 2'b10} wb_sel_e;
    typedef enum logic [1:0] {AS_PC = 2'b00, AS_DIR = 2'b01, AS_RF1 = 2'b10} addr_sel_e;

    typedef struct packed {
        logic [REG_AW-1:0] rf_wa;
        logic              rf_we;
        logic [REG_AW-1:0] rf_r1a;
        logic              rf_r1e;
        logic [REG_AW-1:0] rf_r2a;
        logic              rf_r2e;
        wb_sel_e           wb_sel;
        alu_sel_e          alu_sel;
        addr_sel_e         addr_sel;
        logic              mem_rd;
        logic              mem_wr;
        logic              ir_ld;
        logic              pc_inc;
        logic              pc_ld;
        logic              halted;
    } ctrl_t;
endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_sel_e      sel,
    output logic [DW-1:0] y,
    output logic          zero
);
    always_comb begin
        unique case (sel)
            ALU_SUB: y = a - b;
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic          r1e,
    input  logic [AW-1:0] r1a,
    output logic [DW-1:0] r1d,
    input  logic          r2e,
    input  logic [AW-1:0] r2a,
    output logic [DW-1:0] r2d
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we) regs[wa] <= wd;
    end

    // a disabled read port returns zero so the ALU can pass the other operand
    assign r1d = r1e ? regs[r1a] : '0;
    assign r2d = r2e ? regs[r2a] : '0;
endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
    import cpu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op,
    input  logic [REG_AW-1:0] rn,
    input  logic [REG_AW-1:0] rm,
    input  logic              alu_zero,
    output ctrl_t             c
);
    state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                unique case (op)
                    OP_LDD:  state_d = ST_LDD;
                    OP_STD:  state_d = ST_STD;
                    OP_STI:  state_d = ST_STI;
                    OP_LDI:  state_d = ST_LDI;
                    OP_ADD:  state_d = ST_ADD;
                    OP_SUB:  state_d = ST_SUB;
                    OP_JZ:   state_d = ST_JZ;
                    default: state_d = ST_HALT;
                endcase
            end
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_FETCH;
        endcase
    end

    always_comb begin
        c = '0;
        unique case (state_q)
            ST_FETCH: begin
                c.addr_sel = AS_PC;
                c.mem_rd   = 1'b1;
                c.ir_ld    = 1'b1;
                c.pc_inc   = 1'b1;
            end
            ST_DECODE: ;
            ST_LDD: begin
                c.addr_sel = AS_DIR;
                c.mem_rd   = 1'b1;
                c.rf_we    = 1'b1;
                c.rf_wa    = rn;
                c.wb_sel   = WB_MEM;
            end
            ST_STD: begin
                c.addr_sel = AS_DIR;
                c.mem_wr   = 1'b1;
                c.rf_r2e   = 1'b1;
                c.rf_r2a   = rn;
            end
            ST_STI: begin
                c.addr_sel = AS_RF1;
                c.mem_wr   = 1'b1;
                c.rf_r1e   = 1'b1;
                c.rf_r1a   = rn;
                c.rf_r2e   = 1'b1;
                c.rf_r2a   = rm;
            end
            ST_LDI: begin
                c.rf_we  = 1'b1;
                c.rf_wa  = rn;
                c.wb_sel = WB_IMM;
            end
            ST_ADD, ST_SUB: begin
                c.rf_r1e  = 1'b1;
                c.rf_r1a  = rn;
                c.rf_r2e  = 1'b1;
                c.rf_r2a  = rm;
                c.alu_sel = (state_q == ST_SUB) ? ALU_SUB : ALU_ADD;
                c.rf_we   = 1'b1;
                c.rf_wa   = rn;
                c.wb_sel  = WB_ALU;
            end
            ST_JZ: begin
                c.rf_r1e  = 1'b1;
                c.rf_r1a  = rn;
                c.alu_sel = ALU_ADD;
                c.pc_ld   = alu_zero;
            end
            ST_HALT: c.halted = 1'b1;
        endcase
    end
endmodule

// File: rtl/mc_cpu16.sv
module mc_cpu16
    import cpu16_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int NREG   = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              halted
);
    localparam int RF_AW = $clog2(NREG);

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    ctrl_t             c;
    logic [DATA_W-1:0] rd1, rd2, alu_y, wb_data, imm_ext;
    logic [ADDR_W-1:0] dir_ext;
    logic              alu_zero;

    assign imm_ext = {{(DATA_W-FIELD_W){1'b0}}, ir_q[FIELD_W-1:0]};
    assign dir_ext = {{(ADDR_W-FIELD_W){1'b0}}, ir_q[FIELD_W-1:0]};

    cpu16_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op       (ir_q[15:12]),
        .rn       (ir_q[11:8]),
        .rm       (ir_q[7:4]),
        .alu_zero (alu_zero),
        .c        (c)
    );

    cpu16_regfile #(.DW(DATA_W), .NREG(NREG)) u_rf (
        .clk (clk),
        .we  (c.rf_we),
        .wa  (c.rf_wa[RF_AW-1:0]),
        .wd  (wb_data),
        .r1e (c.rf_r1e),
        .r1a (c.rf_r1a[RF_AW-1:0]),
        .r1d (rd1),
        .r2e (c.rf_r2e),
        .r2a (c.rf_r2a[RF_AW-1:0]),
        .r2d (rd2)
    );

    cpu16_alu #(.DW(DATA_W)) u_alu (
        .a    (rd1),
        .b    (rd2),
        .sel  (c.alu_sel),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        unique case (c.wb_sel)
            WB_MEM:  wb_data = mem_rdata;
            WB_IMM:  wb_data = imm_ext;
            default: wb_data = alu_y;
        endcase
        unique case (c.addr_sel)
            AS_DIR:  mem_addr = dir_ext;
            AS_RF1:  mem_addr = rd1[ADDR_W-1:0];
            default: mem_addr = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (c.ir_ld)       ir_q <= mem_rdata;
            if (c.pc_ld)       pc_q <= dir_ext;
            else if (c.pc_inc) pc_q <= pc_q + 1'b1;
        end
    end

    assign mem_wdata = rd2;
    assign mem_rd    = c.mem_rd;
    assign mem_wr    = c.mem_wr;
    assign halted    = c.halted;
endmodule

// File: rtl/cpu16_chk.sv
module cpu16_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              halted
);
    p_reset_fetch_r1: assert property (@(posedge clk)
        rst |=> (mem_addr == '0 && mem_rd && !mem_wr && !halted));

    p_wr_then_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (mem_rd && !mem_wr));

    p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_idle_r8: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr));

    p_rdwr_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind mc_cpu16 cpu16_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .halted   (halted)
);

// File: tb/sim_mc_cpu16.sv
module sim_mc_cpu16;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, halted;
    logic [15:0] mem [0:255];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    mc_cpu16 u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    localparam int NPROG = 27;
    localparam logic [15:0] PROG [NPROG] = '{
        16'h3000, 16'h310A, 16'h3201, 16'h3300,   // R0=0 R1=10 R2=1 R3=0
        16'h6108, 16'h4010, 16'h5120, 16'h6304,   // loop: jz R1,8; add; sub; jz R3,4
        16'h1080, 16'h0480, 16'h4440, 16'h1481,   // store 55, reload, double, store
        16'h3590, 16'h2510,                        // M[R5]=R1
        16'h36FF, 16'h3700, 16'h5720,             // R6=0xFF, R7=0-1
        16'h1782, 16'h1683,
        16'h6220, 16'h3855, 16'h1884,             // jz not taken, store 0x55
        16'h6318, 16'h1084,                        // jz taken skips next
        16'h3991, 16'h2990,                        // M[R9]=R9
        16'h7000                                   // undefined opcode
    };

    // {requirement number, address, expected word}
    localparam int NEXP = 7;
    localparam logic [39:0] EXP [NEXP] = '{
        {8'd7, 16'h0080, 16'd55},     // R7 loop sum 10..1
        {8'd6, 16'h0081, 16'd110},    // R6 self add, R4 reload
        {8'd5, 16'h0090, 16'h0000},   // R5 indirect store
        {8'd6, 16'h0082, 16'hFFFF},   // R6 subtract wraps
        {8'd3, 16'h0083, 16'h00FF},   // R3 immediate zero-extended
        {8'd7, 16'h0084, 16'h0055},   // R7 untaken then taken jump
        {8'd5, 16'h0091, 16'h0091}    // R5 rn equals rm
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
        for (int i = 0; i < NPROG; i++) mem[i] <= PROG[i];
        mem[8'h90] <= 16'hBEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(mem_rd && mem_addr == 16'h0, "R1 fetch at 0 in reset", {mem_rd, mem_addr}, {1'b1, 16'h0});
        check(!halted && !mem_wr, "R1 halted/wr low", {halted, mem_wr}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_rd && !mem_wr, "R2 decode idle", {mem_rd, mem_wr}, 0);
        @(negedge clk);
        check(!mem_rd && !mem_wr, "R2 imm exec idle", {mem_rd, mem_wr}, 0);
        @(negedge clk);
        check(mem_rd && mem_addr == 16'h1, "R2 second fetch at 1", {mem_rd, mem_addr}, {1'b1, 16'h1});
        while (!halted && cyc < 5000) @(negedge clk);
        check(halted == 1'b1, "R8 halted on opcode 7", halted, 1);
        check(cyc == 188, "R2 R7 cycles to halt", cyc, 188);
        for (int k = 0; k < NEXP; k++)
            check(mem[EXP[k][23:16]] == EXP[k][15:0],
                  $sformatf("R%0d mem[%0h]", EXP[k][39:32], EXP[k][31:16]),
                  mem[EXP[k][23:16]], EXP[k][15:0]);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(halted && !mem_rd && !mem_wr, "R8 halt holds idle", {halted, mem_rd, mem_wr}, 3'b100);
        end
        rst = 1'b1;
        @(negedge clk);
        check(!halted && mem_rd && mem_addr == 16'h0, "R1 reset leaves halt", {halted, mem_rd, mem_addr}, {1'b0, 1'b1, 16'h0});
        rst = 1'b0;
        @(negedge clk);
        check(!mem_rd && !mem_wr && !halted, "R9 decode after restart", {mem_rd, mem_wr, halted}, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule